// File: doc/BRIEF.md
# Adaptive Bang-Bang Fine Tuning Controller

This block steers the fine digital-to-analog code of a burst-mode all-digital PLL. At the end of every burst, a phase decision circuit reports one bit: whether the last counted oscillator edge came after the closing reference edge (late) or before it (early). Fine correction is meaningful only once the coarse frequency loop has settled. So the controller ignores every burst while the coarse loop reports a nonzero error, and keeps its code frozen during that time. Once the coarse error is zero, each burst moves the code one step toward the side that pulls the final oscillator edge onto the reference edge.

The loop bandwidth adapts to how the decisions behave. Tracking starts with a wide step of 16 codes. When the decisions alternate, the loop is dithering around the target, so the controller drops to a single-code step. A long run of decisions in one direction shows that the target has moved away, and the controller returns to the wide step. The code saturates at both ends of its 9-bit range.

Each decision arrives as a one-cycle `burst_done` strobe carrying `late`. The controller accepts every strobe in the cycle it appears and applies no back-pressure, so it has no ready signal. The coarse-zero input is a plain level.

Top module: `bbfine_tune_ctrl`

## Requirements
- R1: After reset, `fine_code` is 256 (mid-scale), the wide step is selected and no decision history is held.
- R2: While `coarse_zero` is 0, `fine_code` does not change, and a `burst_done` strobe in that cycle is ignored.
- R3: An accepted decision with `late`=1 raises `fine_code`; one with `late`=0 lowers it.
- R4: `fine_code` changes only on a clock edge where `burst_done`=1 and `coarse_zero`=1, by exactly one step per strobe, and it is visible one cycle later.
- R5: The wide step moves the code by 16.
- R6: After three consecutive sign changes in the accepted decisions (four alternating decisions), the step becomes 1. The burst that makes the third change still uses the wide step.
- R7: In the narrow-step state, eight consecutive same-sign decisions restore the wide step. The eighth of them still moves the code by 1.
- R8: A cycle with `coarse_zero`=0 returns the controller to the wide step and clears its decision history. The first accepted decision after that never counts as a sign change.
- R9: `fine_code` saturates at 511 when raised and at 0 when lowered, and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_done | input | 1 | One-cycle strobe: a burst has ended and `late` is valid |
| late | input | 1 | 1 = last oscillator edge after reference edge, 0 = before |
| coarse_zero | input | 1 | 1 = coarse loop reports zero error |
| fine_code | output | 9 | Code to the fine DAC |

## Verification
The bound checker enforces four rules on every cycle: the code stays frozen while the coarse error is nonzero and whenever no strobe arrives; accepted decisions move the code in the direction of the late bit; a full wide step of 16 is taken when there is room for it; and a coarse-loop excursion leaves the step state wide. The bench scenarios show the rest: the exact burst on which the step narrows after alternating decisions, the burst on which it widens again after a run of eight, the loss of history after a coarse excursion, and saturation at both ends of the range.

// File: rtl/bbfine_pkg.sv
package bbfine_pkg;
  typedef enum logic {
    STEP_WIDE   = 1'b0,
    STEP_NARROW = 1'b1
  } step_mode_e;
endpackage

// File: rtl/bbfine_mode_tracker.sv
module bbfine_mode_tracker
  import bbfine_pkg::*;
#(
  parameter int ALT_LIMIT = 3,
  parameter int RUN_LIMIT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  logic       hold,
  input  logic       dir_up,
  output step_mode_e mode
);
  localparam int AW = $clog2(ALT_LIMIT + 1);
  localparam int RW = $clog2(RUN_LIMIT + 1);

  logic          have_prev;
  logic          prev_up;
  logic [AW-1:0] alt_cnt, alt_nx;
  logic [RW-1:0] run_cnt, run_nx;
  step_mode_e    mode_nx;
  logic          flip;

  always_comb begin
    flip = have_prev && (dir_up != prev_up);
    if (flip) begin
      alt_nx = (alt_cnt == AW'(ALT_LIMIT)) ? alt_cnt : alt_cnt + AW'(1);
      run_nx = RW'(1);
    end else begin
      alt_nx = '0;
      run_nx = (run_cnt == RW'(RUN_LIMIT)) ? run_cnt : run_cnt + RW'(1);
    end
    mode_nx = mode;
    if (mode == STEP_WIDE && alt_nx == AW'(ALT_LIMIT))
      mode_nx = STEP_NARROW;
    else if (mode == STEP_NARROW && run_nx == RW'(RUN_LIMIT))
      mode_nx = STEP_WIDE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      have_prev <= 1'b0;
      prev_up   <= 1'b0;
      alt_cnt   <= '0;
      run_cnt   <= '0;
      mode      <= STEP_WIDE;
    end else if (upd) begin
      have_prev <= 1'b1;
      prev_up   <= dir_up;
      alt_cnt   <= alt_nx;
      run_cnt   <= run_nx;
      mode      <= mode_nx;
    end
  end
endmodule

// File: rtl/bbfine_code_stepper.sv
module bbfine_code_stepper
  import bbfine_pkg::*;
#(
  parameter int CODE_W     = 9,
  parameter int WIDE_STEP  = 16,
  parameter int NARROW_STEP = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              dir_up,
  input  step_mode_e        mode,
  output logic [CODE_W-1:0] code
);
  localparam int EW = CODE_W + 1;
  localparam logic [EW-1:0]     MAX_CODE = EW'((1 << CODE_W) - 1);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1 << (CODE_W - 1));

  logic [EW-1:0]     step, wide, sum, diff;
  logic [CODE_W-1:0] code_nx;

  always_comb begin
    step = (mode == STEP_NARROW) ? EW'(NARROW_STEP) : EW'(WIDE_STEP);
    wide = {1'b0, code};
    sum  = wide + step;
    diff = wide - step;
    if (dir_up)
      code_nx = (sum > MAX_CODE) ? MAX_CODE[CODE_W-1:0] : sum[CODE_W-1:0];
    else
      code_nx = (wide < step) ? '0 : diff[CODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   code <= MID_CODE;
    else if (upd) code <= code_nx;
  end
endmodule

// File: rtl/bbfine_tune_ctrl.sv
module bbfine_tune_ctrl
  import bbfine_pkg::*;
#(
  parameter int CODE_W      = 9,
  parameter int WIDE_STEP   = 16,
  parameter int NARROW_STEP = 1,
  parameter int ALT_LIMIT   = 3,
  parameter int RUN_LIMIT   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_done,
  input  logic              late,
  input  logic              coarse_zero,
  output logic [CODE_W-1:0] fine_code
);
  logic       accept;
  logic       hold;
  step_mode_e step_mode;

  assign accept = burst_done & coarse_zero;
  assign hold   = ~coarse_zero;

  bbfine_mode_tracker #(
    .ALT_LIMIT(ALT_LIMIT),
    .RUN_LIMIT(RUN_LIMIT)
  ) u_track (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (accept),
    .hold  (hold),
    .dir_up(late),
    .mode  (step_mode)
  );

  bbfine_code_stepper #(
    .CODE_W     (CODE_W),
    .WIDE_STEP  (WIDE_STEP),
    .NARROW_STEP(NARROW_STEP)
  ) u_step (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (accept),
    .dir_up(late),
    .mode  (step_mode),
    .code  (fine_code)
  );
endmodule

// File: rtl/bbfine_tune_chk.sv
module bbfine_tune_chk
  import bbfine_pkg::*;
#(
  parameter int CODE_W    = 9,
  parameter int WIDE_STEP = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              burst_done,
  input logic              late,
  input logic              coarse_zero,
  input logic [CODE_W-1:0] fine_code,
  input step_mode_e        step_mode
);
  localparam int EW = CODE_W + 1;
  localparam logic [EW-1:0] ROOM = EW'((1 << CODE_W) - 1 - WIDE_STEP);

  AST_FROZEN_COARSE: assert property (@(posedge clk) disable iff (!rst_n)
    !coarse_zero |=> fine_code == $past(fine_code)); // R2

  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_done |=> fine_code == $past(fine_code)); // R4

  AST_DOWN_ON_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done && coarse_zero && !late && fine_code != '0)
      |=> fine_code < $past(fine_code)); // R3

  AST_UP_ON_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done && coarse_zero && late && fine_code != '1)
      |=> fine_code > $past(fine_code)); // R3

  AST_WIDE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done && coarse_zero && late && step_mode == STEP_WIDE && {1'b0, fine_code} <= ROOM)
      |=> {1'b0, fine_code} == {1'b0, $past(fine_code)} + EW'(WIDE_STEP)); // R5

  AST_REVERT_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !coarse_zero |=> step_mode == STEP_WIDE); // R8
endmodule

bind bbfine_tune_ctrl bbfine_tune_chk #(
  .CODE_W   (CODE_W),
  .WIDE_STEP(WIDE_STEP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .burst_done (burst_done),
  .late       (late),
  .coarse_zero(coarse_zero),
  .fine_code  (fine_code),
  .step_mode  (step_mode)
);

// File: tb/tb_bbfine_tune_ctrl.sv
module tb_bbfine_tune_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       burst_done = 1'b0;
  logic       late = 1'b0;
  logic       coarse_zero = 1'b0;
  logic [8:0] fine_code;
  int         n_chk = 0;
  int         n_bad = 0;
  logic       done = 1'b0;

  always #2.5 clk = ~clk;

  bbfine_tune_ctrl dut (
    .clk(clk), .rst_n(rst_n), .burst_done(burst_done),
    .late(late), .coarse_zero(coarse_zero), .fine_code(fine_code)
  );

  // {coarse_zero, late, expected fine_code after the burst}
  localparam int NV = 21;
  localparam logic [10:0] VEC [NV] = '{
    {1'b1, 1'b1, 9'd272},  // R5 wide step up
    {1'b1, 1'b1, 9'd288},  // R3
    {1'b1, 1'b0, 9'd272},  // R3 down, change 1
    {1'b1, 1'b1, 9'd288},  // change 2
    {1'b1, 1'b0, 9'd272},  // R6 change 3 still wide
    {1'b1, 1'b1, 9'd273},  // R6 narrow now
    {1'b1, 1'b1, 9'd274},
    {1'b1, 1'b1, 9'd275},
    {1'b1, 1'b1, 9'd276},
    {1'b1, 1'b1, 9'd277},
    {1'b1, 1'b1, 9'd278},
    {1'b1, 1'b1, 9'd279},
    {1'b1, 1'b1, 9'd280},  // R7 eighth same-sign still narrow
    {1'b1, 1'b1, 9'd296},  // R7 wide again
    {1'b0, 1'b1, 9'd296},  // R2 ignored while coarse nonzero
    {1'b1, 1'b0, 9'd280},  // R8 history cleared
    {1'b1, 1'b1, 9'd296},
    {1'b1, 1'b0, 9'd280},
    {1'b1, 1'b1, 9'd296},  // third change -> narrow
    {1'b0, 1'b0, 9'd296},  // R2 R8 freeze and revert
    {1'b1, 1'b0, 9'd280}   // R8 wide step after revert
  };

  task automatic check(input string req, input logic [8:0] exp);
    n_chk++;
    if (fine_code !== exp) begin
      n_bad++;
      $display("FAIL %s: fine_code=%0d expected=%0d", req, fine_code, exp);
    end
  endtask

  task automatic burst(input logic cz, input logic lt);
    @(negedge clk);
    coarse_zero = cz;
    late        = lt;
    burst_done  = 1'b1;
    @(negedge clk);
    burst_done  = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    check("R1 reset value", 9'd256);

    for (int i = 0; i < NV; i++) begin
      burst(VEC[i][10], VEC[i][9]);
      check($sformatf("R4 vector %0d", i), VEC[i][8:0]);
    end

    // R4: no strobe, late toggling, code holds
    coarse_zero = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      late = ~late;
    end
    @(negedge clk);
    check("R4 no strobe hold", 9'd280);

    // R1: reset mid-run returns mid-scale and wide step
    do_reset();
    check("R1 reset mid-run", 9'd256);
    burst(1'b1, 1'b1);
    check("R1 wide step after reset", 9'd272);

    // R9: upper saturation (272 + 14*16 = 496, then clamp)
    for (int i = 0; i < 14; i++) burst(1'b1, 1'b1);
    check("R9 approach top", 9'd496);
    burst(1'b1, 1'b1);
    check("R9 clamp at 511", 9'd511);
    burst(1'b1, 1'b1);
    check("R9 stay at 511", 9'd511);

    // R9: lower saturation
    do_reset();
    for (int i = 0; i < 16; i++) burst(1'b1, 1'b0);
    check("R9 reach 0", 9'd0);
    burst(1'b1, 1'b0);
    check("R9 stay at 0", 9'd0);
    burst(1'b1, 1'b1);
    check("R3 up from 0", 9'd16);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: fine_code=%0d expected=completion", fine_code);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule